// File: doc/BRIEF.md
# Programmable Countdown Interval Timer

This block is an 8-bit interval timer that counts down on one of four source-clock strobes chosen by software. A prescaler outside the block supplies the strobes, which run at 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz. Each time the count runs out, a timer flag is set and the count starts again from the programmed value. The block also takes a 1 Hz tick and a once-per-minute tick, and it can raise a shared second/minute flag on either one.

The interrupt output runs in one of two modes. In level mode it follows the enabled flags. In pulse mode it gives a single-cycle pulse for each enabled event. Software reaches the block through a simple register port: a write strobe, a 2-bit address and 8-bit write data, with combinational read data. Both flags are cleared by writing 0 to their bit position.

The periods range from 244 µs (4096 Hz source, value 1) to about 4.25 hours (1/60 Hz source, value 255).

Top module: `cdt_top`

## Requirements
- R1: After reset, the timer control register reads 0x03, the interrupt control register reads 0x00, the countdown value reads 0x00, and the live count reads 0x00. After reset, `tmr_flag`, `ms_flag` and `irq` are all 0.
- R2: The register map is as follows.
  - Address 0 is interrupt control:
    - bit 7: minute enable
    - bit 6: second enable
    - bit 5: second/minute flag
    - bit 4: pulse mode
    - bit 2: timer flag
    - bit 0: timer interrupt enable
    - bits 3 and 1 read 0.
  - Address 1 is timer control: bit 7 is run enable, bits 1:0 are the source select, and the other bits read 0.
  - Address 2 is the countdown value.
  - Address 3 reads the live count, and writes to it are ignored.
- R3: The source select decides which strobe drives the count: 0 picks `src_tick[0]` (4096 Hz), 1 picks `src_tick[1]` (64 Hz), 2 picks `src_tick[2]` (1 Hz) and 3 picks `src_tick[3]` (1/60 Hz). Strobes on sources that are not selected leave the count unchanged.
- R4: While run enable is 0, the live count equals the countdown value one cycle later, and the timer never expires.
- R5: While running, each selected strobe lowers the count by one. When a strobe arrives with the count at 1 or 0, the timer flag is set and the count reloads from the countdown value. A value N ≥ 1 therefore expires every N strobes, and 0 expires on every strobe.
- R6: A write to the countdown value also loads the live count at the same edge. This restarts a running count, and a strobe in that same cycle causes no expiry.
- R7: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. If a flag is set and cleared in the same cycle, setting wins.
- R8: The second/minute flag sets on `sec_tick` only when second enable is 1, and on `min_tick` only when minute enable is 1.
- R9: In level mode (pulse mode = 0), `irq` is 1 exactly when (timer flag and timer interrupt enable) or the second/minute flag is 1.
- R10: In pulse mode, `irq` is high for the one cycle after each enabled event (an expiry with timer interrupt enable set, or an enabled second/minute tick), whatever the state of the flags.
- R11: The live count never exceeds the countdown value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Single-cycle source-clock strobes, index = select code |
| sec_tick | input | 1 | Single-cycle once-per-second strobe |
| min_tick | input | 1 | Single-cycle once-per-minute strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational on `addr`) |
| tmr_flag | output | 1 | Timer expiry flag |
| ms_flag | output | 1 | Second/minute event flag |
| irq | output | 1 | Interrupt output, level or pulse |

## Verification
The assertions check the following on every cycle:
- the live count never rises above the programmed value;
- the count holds when running without a selected strobe;
- a stopped count tracks the programmed value;
- each rise of a flag and each pulse-mode interrupt traces back to a qualifying event the cycle before.

Only the bench scenarios can show that:
- the right strobe is picked for each select code;
- expiry falls on exactly the Nth strobe;
- the clear-on-write-zero rule and the set-over-clear priority behave correctly;
- level and pulse interrupt shapes match the requirements.

The bench covers these with a sweep over all four sources and several countdown values.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned N_SRC = 4;
  localparam int unsigned SEL_W = $clog2(N_SRC);

  localparam logic [1:0] A_ICTL = 2'd0;
  localparam logic [1:0] A_TCTL = 2'd1;
  localparam logic [1:0] A_LOAD = 2'd2;
  localparam logic [1:0] A_LIVE = 2'd3;

  localparam int unsigned B_MIE = 7;
  localparam int unsigned B_SIE = 6;
  localparam int unsigned B_MSF = 5;
  localparam int unsigned B_PLS = 4;
  localparam int unsigned B_TF  = 2;
  localparam int unsigned B_TIE = 0;
  localparam int unsigned B_RUN = 7;

  // count at or below one runs out on the next strobe
  function automatic logic cdt_expires(input logic [DW-1:0] cnt);
    return cnt <= DW'(1);
  endfunction

  function automatic logic [DW-1:0] cdt_step(input logic [DW-1:0] cnt,
                                             input logic [DW-1:0] load);
    return cdt_expires(cnt) ? load : cnt - DW'(1);
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic             min_ie,
  output logic             sec_ie,
  output logic             pulse_mode,
  output logic             tie,
  output logic             run,
  output logic [SEL_W-1:0] sel,
  output logic [DW-1:0]    load_val,
  output logic             ictl_wr,
  output logic             load_wr
);
  assign ictl_wr = wr_en && (addr == A_ICTL);
  assign load_wr = wr_en && (addr == A_LOAD);

  logic tctl_wr;
  assign tctl_wr = wr_en && (addr == A_TCTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_ie     <= 1'b0;
      sec_ie     <= 1'b0;
      pulse_mode <= 1'b0;
      tie        <= 1'b0;
      run        <= 1'b0;
      sel        <= '1;
      load_val   <= '0;
    end else begin
      if (ictl_wr) begin
        min_ie     <= wdata[B_MIE];
        sec_ie     <= wdata[B_SIE];
        pulse_mode <= wdata[B_PLS];
        tie        <= wdata[B_TIE];
      end
      if (tctl_wr) begin
        run <= wdata[B_RUN];
        sel <= wdata[SEL_W-1:0];
      end
      if (load_wr) load_val <= wdata;
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             run,
  input  logic [DW-1:0]    load_val,
  input  logic             load_wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cnt,
  output logic             exp_ev
);
  logic tick_sel;
  assign tick_sel = src_tick[sel];
  assign exp_ev   = run && tick_sel && !load_wr && cdt_expires(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load_wr)    cnt <= wdata;
    else if (!run)       cnt <= load_val;
    else if (tick_sel)   cnt <= cdt_step(cnt, load_val);
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick_sel && !load_wr |=> $stable(cnt));

  // R4
  cnt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load_wr |=> cnt == $past(load_val));

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt == $past(wdata));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq
  import cdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exp_ev,
  input  logic sec_tick,
  input  logic min_tick,
  input  logic sec_ie,
  input  logic min_ie,
  input  logic tie,
  input  logic pulse_mode,
  input  logic ictl_wr,
  input  logic tf_keep,
  input  logic msf_keep,
  output logic tf,
  output logic msf,
  output logic irq
);
  logic ms_ev, any_ev, pulse_q;
  assign ms_ev  = (sec_tick && sec_ie) || (min_tick && min_ie);
  assign any_ev = (exp_ev && tie) || ms_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf      <= 1'b0;
      msf     <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (exp_ev)                     tf <= 1'b1;
      else if (ictl_wr && !tf_keep)   tf <= 1'b0;
      if (ms_ev)                      msf <= 1'b1;
      else if (ictl_wr && !msf_keep)  msf <= 1'b0;
      pulse_q <= any_ev;
    end
  end

  assign irq = pulse_mode ? pulse_q : ((tf && tie) || msf);

  // R5
  tf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf) |-> $past(exp_ev));

  // R8
  msf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msf) |-> $past(ms_ev));

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_mode && irq |-> $past(any_ev));

  // R7
  tf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_ev |=> tf);
endmodule

// File: rtl/cdt_top.sv
module cdt_top
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_tick,
  input  logic             sec_tick,
  input  logic             min_tick,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             tmr_flag,
  output logic             ms_flag,
  output logic             irq
);
  logic             min_ie, sec_ie, pulse_mode, tie, run, ictl_wr, load_wr, exp_ev;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    load_val, cnt;

  cdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .min_ie(min_ie), .sec_ie(sec_ie), .pulse_mode(pulse_mode), .tie(tie),
    .run(run), .sel(sel), .load_val(load_val), .ictl_wr(ictl_wr),
    .load_wr(load_wr)
  );

  cdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(sel), .run(run),
    .load_val(load_val), .load_wr(load_wr), .wdata(wdata), .cnt(cnt),
    .exp_ev(exp_ev)
  );

  cdt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .exp_ev(exp_ev), .sec_tick(sec_tick),
    .min_tick(min_tick), .sec_ie(sec_ie), .min_ie(min_ie), .tie(tie),
    .pulse_mode(pulse_mode), .ictl_wr(ictl_wr), .tf_keep(wdata[B_TF]),
    .msf_keep(wdata[B_MSF]), .tf(tmr_flag), .msf(ms_flag), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_ICTL: begin
        rdata[B_MIE] = min_ie;
        rdata[B_SIE] = sec_ie;
        rdata[B_MSF] = ms_flag;
        rdata[B_PLS] = pulse_mode;
        rdata[B_TF]  = tmr_flag;
        rdata[B_TIE] = tie;
      end
      A_TCTL: begin
        rdata[B_RUN]       = run;
        rdata[SEL_W-1:0]   = sel;
      end
      A_LOAD:  rdata = load_val;
      default: rdata = cnt;
    endcase
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= load_val);
endmodule

// File: tb/cdt_top_tb.sv
`timescale 1ns/1ps
module cdt_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic       sec_tick = 1'b0, min_tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tmr_flag, ms_flag, irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sec_tick(sec_tick),
    .min_tick(min_tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tmr_flag(tmr_flag), .ms_flag(ms_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic tick(input int i);
    @(negedge clk); src_tick[i] = 1'b1;
    @(negedge clk); src_tick = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(1, v); chk("R1 tctl", v, 8'h03);
    peek(0, v); chk("R1 ictl", v, 8'h00);
    peek(2, v); chk("R1 load", v, 8'h00);
    peek(3, v); chk("R1 live", v, 8'h00);
    chk("R1 flags/irq", {tmr_flag, ms_flag, irq}, 0);

    // R2 register map
    wr(1, 8'hFF); peek(1, v); chk("R2 tctl mask", v, 8'h83);
    wr(0, 8'hFF); peek(0, v); chk("R2 ictl mask", v, 8'hD1);
    wr(0, 8'h00); wr(1, 8'h00);
    wr(2, 8'h5A); wr(3, 8'h11);
    peek(2, v); chk("R2 load after live write", v, 8'h5A);
    peek(3, v); chk("R2 live read", v, 8'h5A);

    // R4 stopped timer ignores strobes
    for (int i = 0; i < 4; i++) tick(0);
    peek(3, v); chk("R4 stopped count", v, 8'h5A);
    chk("R4 no flag", tmr_flag, 0);

    // R3 R5 R9 sweep over sources and values
    for (int s = 0; s < 4; s++) begin
      for (int ri = 0; ri < 4; ri++) begin
        int rl, n;
        rl = (ri == 0) ? 0 : (ri == 1) ? 1 : (ri == 2) ? 3 : 5;
        n  = (rl == 0) ? 1 : rl;
        wr(1, 8'(s)); wr(2, 8'(rl)); wr(0, 8'h01); wr(1, 8'(8'h80 | s));
        tick((s + 1) % 4);
        peek(3, v); chk("R3 unselected strobe", v, rl);
        chk("R3 no flag on unselected", tmr_flag, 0);
        for (int k = 1; k <= 2 * n + 1; k++) begin
          int e;
          tick(s);
          e = (k % n == 0) ? rl : n - (k % n);
          peek(3, v); chk("R5 count", v, e);
          chk("R5 flag", tmr_flag, (k >= n) ? 1 : 0);
          chk("R9 level irq", irq, (k >= n) ? 1 : 0);
        end
      end
    end

    // R6 restart on write while running
    wr(1, 8'h80); wr(2, 8'd5); wr(0, 8'h00);
    tick(0); tick(0);
    peek(3, v); chk("R6 before", v, 3);
    wr(2, 8'd9);
    peek(3, v); chk("R6 restart live", v, 9);
    @(negedge clk); wr_en = 1'b1; addr = 2; wdata = 8'd1; src_tick[0] = 1'b1;
    @(negedge clk); wr_en = 1'b0; src_tick = '0;
    chk("R6 no expiry on restart", tmr_flag, 0);
    peek(3, v); chk("R6 restart value", v, 1);

    // R7 set beats clear; write 1 keeps, write 0 clears
    @(negedge clk); wr_en = 1'b1; addr = 0; wdata = 8'h00; src_tick[0] = 1'b1;
    @(negedge clk); wr_en = 1'b0; src_tick = '0;
    chk("R7 set wins", tmr_flag, 1);
    wr(0, 8'h04); chk("R7 write 1 keeps", tmr_flag, 1);
    wr(0, 8'h00); chk("R7 write 0 clears", tmr_flag, 0);

    // R8 second/minute flag
    wr(0, 8'h40);
    @(negedge clk); min_tick = 1'b1; @(negedge clk); min_tick = 1'b0;
    chk("R8 minute disabled", ms_flag, 0);
    @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
    chk("R8 second enabled", ms_flag, 1);
    chk("R9 level irq msf", irq, 1);
    wr(0, 8'h80); chk("R7 msf cleared", ms_flag, 0);
    @(negedge clk); min_tick = 1'b1; @(negedge clk); min_tick = 1'b0;
    chk("R8 minute enabled", ms_flag, 1);
    @(negedge clk); min_tick = 1'b1; @(negedge clk); min_tick = 1'b0;

    // R10 pulse mode
    wr(0, 8'h11); wr(2, 8'd1);
    chk("R10 idle", irq, 0);
    tick(0);
    chk("R10 pulse high", irq, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", irq, 0);
    chk("R10 flag still set", tmr_flag, 1);
    wr(0, 8'h05); chk("R9 level after mode change", irq, 1);
    wr(0, 8'h01); chk("R9 level clears", irq, 0);
    summary();
  end
endmodule